// File: doc/BRIEF.md
# Five-Step Multi-Cycle Integer Core

This block is a small 32-bit integer core without pipelining. Each instruction is taken through a fixed series of register-transfer steps, one step per clock: fetch, decode with operand read, execute or address add, memory access or branch resolution, and an optional write-back. The step count depends on the instruction class. Stores, branches and any unrecognised encoding finish after the memory step, in four clocks. Loads and arithmetic or logic operations need a fifth clock to write the register file.

Instruction memory and data memory are inside the block. Both are word-addressed and read combinationally. The values they present are captured in the instruction register and the load-data register. A loader write port fills either memory while the core is held in reset. A debug port reads any register combinationally. The program counter is an output, and a one-cycle retire strobe marks the last clock of every instruction.

Top module: `seq_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to the fetch step with `pc_o` = 0. `retire_o` is low in the cycle that follows.
- R2: Instruction fields are numbered with bit 0 as the MSB (word bit 31). The opcode is bits 0..5. Source register s is bits 6..10. Register t is bits 11..15. The register-register destination is bits 16..20. The function code is the low six bits (word bits 5..0). The immediate is bits 16..31, sign-extended to 32 bits.
- R3: Opcode 0x00 is register-register. Function code 0x20 gives ADD, 0x22 SUB, 0x24 AND, 0x25 OR, 0x26 XOR and 0x2A signed set-less-than (result 1 or 0). The operands are registers s and t, and the result goes to the destination register.
- R4: Register-immediate opcodes apply the operation to register s and the sign-extended immediate, and write the result to register t. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C AND, 0x0D OR and 0x0E XOR.
- R5: Opcode 0x23 loads the data word at byte address s + immediate into register t.
- R6: Opcode 0x2B stores register t to the data word at byte address s + immediate.
- R7: Opcode 0x04 branches when register s is zero. The next PC is then PC + 4 + immediate; otherwise it is PC + 4.
- R8: Register 0 always reads as zero. Writes to register 0 have no effect.
- R9: Loads and register-register or register-immediate operations take five clocks. Stores and branches take four. `retire_o` is high for exactly the final clock, and the next clock is a fetch.
- R10: Any other opcode, and opcode 0x00 with any other function code, acts as a no-op. It takes four clocks, changes no register and advances the PC by 4.
- R11: The PC changes only at the end of the memory step. A non-branch instruction always advances it by 4.
- R12: While in reset, `imem_load_we` or `dmem_load_we` writes `load_word` to word `load_idx` of the chosen memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_load_we | input | 1 | Loader write strobe for instruction memory |
| dmem_load_we | input | 1 | Loader write strobe for data memory |
| load_idx | input | LDW (6) | Loader word index |
| load_word | input | 32 | Loader write data |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Register value, combinational |
| pc_o | output | 32 | Program counter |
| retire_o | output | 1 | High in the last clock of each instruction |

## Verification
The assertions assume the loader strobes are used only while `rst` is high. They also assume that every PC reached, and every load or store address, falls inside the memories. The bench preloads both memories in reset and then only releases reset. Its programs use word-aligned addresses well below the memory size. Branch targets land on real instructions, and every program ends with a branch that targets itself. The bench stops each run when it sees that branch retire.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD = 32;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_e;
  typedef enum logic [2:0] {K_RR, K_RI, K_LOAD, K_STORE, K_BRZ, K_NOP} kind_e;
  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLT} aluop_e;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_BRZ  = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  function automatic logic fn_known(input logic [5:0] fn);
    return fn inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT};
  endfunction

  function automatic kind_e classify(input logic [5:0] opc, input logic [5:0] fn);
    kind_e k;
    case (opc)
      OPC_RR:   k = fn_known(fn) ? K_RR : K_NOP;
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: k = K_RI;
      OPC_LW:   k = K_LOAD;
      OPC_SW:   k = K_STORE;
      OPC_BRZ:  k = K_BRZ;
      default:  k = K_NOP;
    endcase
    return k;
  endfunction

  function automatic logic writes_back(input kind_e k);
    return k inside {K_RR, K_RI, K_LOAD};
  endfunction

  function automatic aluop_e select_op(input kind_e k, input logic [5:0] opc,
                                       input logic [5:0] fn);
    aluop_e op;
    op = OP_ADD;
    if (k == K_RR) begin
      case (fn)
        FN_SUB:  op = OP_SUB;
        FN_AND:  op = OP_AND;
        FN_OR:   op = OP_OR;
        FN_XOR:  op = OP_XOR;
        FN_SLT:  op = OP_SLT;
        default: op = OP_ADD;
      endcase
    end else if (k == K_RI) begin
      case (opc)
        OPC_SLTI: op = OP_SLT;
        OPC_ANDI: op = OP_AND;
        OPC_ORI:  op = OP_OR;
        OPC_XORI: op = OP_XOR;
        default:  op = OP_ADD;
      endcase
    end
    return op;
  endfunction

  function automatic logic [WORD-1:0] alu_eval(input aluop_e op, input logic [WORD-1:0] a,
                                               input logic [WORD-1:0] b);
    logic [WORD-1:0] y;
    case (op)
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = {{(WORD-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
    return y;
  endfunction

  function automatic logic [WORD-1:0] sext16(input logic [15:0] v);
    return {{(WORD-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/seq_mem.sv
module seq_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int RAW = $clog2(NREG)
)(
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ra,
  input  logic [RAW-1:0] rb,
  input  logic [RAW-1:0] rdbg,
  output logic [DW-1:0]  qa,
  output logic [DW-1:0]  qb,
  output logic [DW-1:0]  qdbg
);
  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_live
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (we && waddr == RAW'(g)) q <= wdata;
      end
      assign bank[g] = q;
    end
  end

  assign qa   = bank[ra];
  assign qb   = bank[rb];
  assign qdbg = bank[rdbg];
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
(
  input  aluop_e          op,
  input  logic [WORD-1:0] a,
  input  logic [WORD-1:0] b,
  output logic [WORD-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int LDW = (IAW > DAW) ? IAW : DAW
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_load_we,
  input  logic            dmem_load_we,
  input  logic [LDW-1:0]  load_idx,
  input  logic [WORD-1:0] load_word,
  input  logic [4:0]      dbg_sel,
  output logic [WORD-1:0] dbg_data,
  output logic [WORD-1:0] pc_o,
  output logic            retire_o
);
  step_e state_q, state_d;
  logic [WORD-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;

  // instruction fields (bit 0 of the format is word bit 31)
  logic [5:0] opc_w, fn_w;
  logic [4:0] rs_w, rt_w, rd_w;
  kind_e      kind_w;
  logic       long_w;
  assign opc_w  = ir_q[31:26];
  assign rs_w   = ir_q[25:21];
  assign rt_w   = ir_q[20:16];
  assign rd_w   = ir_q[15:11];
  assign fn_w   = ir_q[5:0];
  assign kind_w = classify(opc_w, fn_w);
  assign long_w = writes_back(kind_w);

  // named step events
  logic fetch_ev, decode_ev, exec_ev, mem_ev, wb_ev;
  logic store_fire, load_fire, br_take;
  assign fetch_ev   = (state_q == ST_FETCH);
  assign decode_ev  = (state_q == ST_DECODE);
  assign exec_ev    = (state_q == ST_EXEC);
  assign mem_ev     = (state_q == ST_MEM);
  assign wb_ev      = (state_q == ST_WB);
  assign store_fire = mem_ev && (kind_w == K_STORE);
  assign load_fire  = mem_ev && (kind_w == K_LOAD);
  assign br_take    = mem_ev && (kind_w == K_BRZ) && cond_q;

  // memories
  logic [WORD-1:0] imem_rd, dmem_rd, dmem_wd;
  logic [DAW-1:0]  dmem_wa;
  logic            dmem_we;
  assign dmem_we = dmem_load_we | store_fire;
  assign dmem_wa = dmem_load_we ? load_idx[DAW-1:0] : alu_q[DAW+1:2];
  assign dmem_wd = dmem_load_we ? load_word : b_q;

  seq_mem #(.DEPTH(IMEM_DEPTH), .DW(WORD)) u_imem (
    .clk(clk), .we(imem_load_we), .waddr(load_idx[IAW-1:0]), .wdata(load_word),
    .raddr(pc_q[IAW+1:2]), .rdata(imem_rd)
  );

  seq_mem #(.DEPTH(DMEM_DEPTH), .DW(WORD)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_wa), .wdata(dmem_wd),
    .raddr(alu_q[DAW+1:2]), .rdata(dmem_rd)
  );

  // register file
  logic [WORD-1:0] rf_a, rf_b, wb_data;
  logic [4:0]      wb_addr;
  logic            rf_we;
  assign rf_we   = wb_ev;
  assign wb_addr = (kind_w == K_RR) ? rd_w : rt_w;
  assign wb_data = (kind_w == K_LOAD) ? lmd_q : alu_q;

  seq_regfile #(.NREG(32), .DW(WORD)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wb_addr), .wdata(wb_data),
    .ra(rs_w), .rb(rt_w), .rdbg(dbg_sel),
    .qa(rf_a), .qb(rf_b), .qdbg(dbg_data)
  );

  // execute datapath
  logic [WORD-1:0] alu_a, alu_b, alu_y;
  aluop_e          alu_op;
  assign alu_a  = (kind_w == K_BRZ) ? npc_q : a_q;
  assign alu_b  = (kind_w == K_RR) ? b_q : imm_q;
  assign alu_op = select_op(kind_w, opc_w, fn_w);

  seq_alu u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  // step sequencing
  always_comb begin
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_MEM;
      ST_MEM:    state_d = long_w ? ST_WB : ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      npc_q   <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      imm_q   <= '0;
      alu_q   <= '0;
      lmd_q   <= '0;
      cond_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fetch_ev) begin
        ir_q  <= imem_rd;
        npc_q <= pc_q + WORD'(4);
      end
      if (decode_ev) begin
        a_q   <= rf_a;
        b_q   <= rf_b;
        imm_q <= sext16(ir_q[15:0]);
      end
      if (exec_ev) begin
        alu_q <= alu_y;
        if (kind_w == K_BRZ) cond_q <= (a_q == '0);
      end
      if (load_fire) lmd_q <= dmem_rd;
      if (mem_ev) pc_q <= br_take ? alu_q : npc_q;
    end
  end

  assign pc_o     = pc_q;
  assign retire_o = (mem_ev && !long_w) || wb_ev;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
  import seq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input step_e           state_q,
  input kind_e           kind_w,
  input logic            retire_o,
  input logic [WORD-1:0] pc_o,
  input logic [WORD-1:0] npc_q,
  input logic [WORD-1:0] alu_q,
  input logic            cond_q,
  input logic [4:0]      dbg_sel,
  input logic [WORD-1:0] dbg_data
);
  // clocks spent in the current instruction, 1 in its fetch step
  logic [2:0] span_q;
  always_ff @(posedge clk) begin
    if (rst || retire_o) span_q <= 3'd1;
    else if (span_q != 3'd7) span_q <= span_q + 3'd1;
  end

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !retire_o && state_q == ST_FETCH));

  p_len_r9: assert property (@(posedge clk) disable iff (rst)
    retire_o |-> (span_q == (writes_back(kind_w) ? 3'd5 : 3'd4)));

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    retire_o |=> (!retire_o && state_q == ST_FETCH));

  p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_MEM) |=> $stable(pc_o));

  p_br_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && kind_w == K_BRZ && cond_q) |=> (pc_o == $past(alu_q)));

  p_seq_pc_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && kind_w != K_BRZ) |=> (pc_o == $past(npc_q)));

  p_r0_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 5'd0) |-> (dbg_data == '0));
endmodule

bind seq_core seq_core_chk u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .kind_w(kind_w), .retire_o(retire_o),
  .pc_o(pc_o), .npc_q(npc_q), .alu_q(alu_q), .cond_q(cond_q),
  .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/tb_seq_core.sv
module tb_seq_core;
  localparam int LDW  = 6;
  localparam int NPRG = 24;
  localparam logic [31:0] HALT_PC = 32'd92;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic           imem_we = 1'b0, dmem_we = 1'b0;
  logic [LDW-1:0] lidx = '0;
  logic [31:0]    lword = '0;
  logic [4:0]     dsel = '0;
  logic [31:0]    ddata, pc;
  logic           ret;

  seq_core dut (
    .clk(clk), .rst(rst), .imem_load_we(imem_we), .dmem_load_we(dmem_we),
    .load_idx(lidx), .load_word(lword), .dbg_sel(dsel), .dbg_data(ddata),
    .pc_o(pc), .retire_o(ret)
  );

  int n_chk = 0, n_bad = 0, tick = 0;
  logic [31:0] prog [NPRG];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      n_bad++;
      $display("FAIL R9 watchdog expired: actual %0d expected <150000", tick);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] f_r(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] f_i(input logic [5:0] op, input int s, input int t,
                                      input logic [15:0] k);
    return {op, 5'(s), 5'(t), k};
  endfunction

  // reference arithmetic: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 signed less-than
  function automatic logic [31:0] ref_op(input int sel, input logic [31:0] x, input logic [31:0] y);
    case (sel)
      0: return x + y;
      1: return x + ~y + 32'd1;
      2: return x & y;
      3: return x | y;
      4: return x ^ y;
      default: return (x[31] != y[31]) ? {31'd0, x[31]} : {31'd0, (x < y)};
    endcase
  endfunction

  function automatic int ref_len(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    if (op == 6'h00)
      return (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 ||
              fn == 6'h26 || fn == 6'h2A) ? 5 : 4;
    if (op == 6'h08 || op == 6'h0A || op == 6'h0C || op == 6'h0D ||
        op == 6'h0E || op == 6'h23)
      return 5;
    return 4;
  endfunction

  task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic [15:0] k);
    logic [31:0] ks, spc, exp_pc, src;
    logic [31:0] er [16];
    int cnt;
    bit done;
    ks = {{16{k[15]}}, k};
    prog[0]  = f_i(6'h23, 0, 1, 16'd0);
    prog[1]  = f_i(6'h23, 0, 2, 16'd4);
    prog[2]  = f_r(1, 2, 3, 6'h20);
    prog[3]  = f_r(1, 2, 4, 6'h22);
    prog[4]  = f_r(1, 2, 5, 6'h24);
    prog[5]  = f_r(1, 2, 6, 6'h25);
    prog[6]  = f_r(1, 2, 7, 6'h26);
    prog[7]  = f_r(1, 2, 8, 6'h2A);
    prog[8]  = f_i(6'h08, 1, 9, k);
    prog[9]  = f_i(6'h0C, 1, 10, k);
    prog[10] = f_i(6'h0D, 1, 11, k);
    prog[11] = f_i(6'h0E, 1, 12, k);
    prog[12] = f_i(6'h0A, 1, 13, k);
    prog[13] = f_i(6'h2B, 0, 3, 16'd8);
    prog[14] = f_i(6'h23, 0, 14, 16'd8);
    prog[15] = f_i(6'h08, 0, 15, 16'd3);
    prog[16] = f_r(1, 2, 0, 6'h20);
    prog[17] = f_i(6'h04, 0, 0, 16'd4);
    prog[18] = f_i(6'h08, 0, 1, 16'h0055);
    prog[19] = f_i(6'h04, 2, 0, 16'd4);
    prog[20] = f_i(6'h08, 0, 15, 16'd7);
    prog[21] = {6'h3F, 26'h0000123};
    prog[22] = f_r(1, 2, 7, 6'h01);
    prog[23] = f_i(6'h04, 0, 0, 16'hFFFC);

    // R12: preload while held in reset
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NPRG; i++) begin
      imem_we = 1'b1; lidx = LDW'(i); lword = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    dmem_we = 1'b1; lidx = LDW'(0); lword = a;
    @(negedge clk);
    lidx = LDW'(1); lword = b;
    @(negedge clk);
    dmem_we = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", pc, 32'd0);
    check("R1", "retire in reset", {31'd0, ret}, 32'd0);
    rst = 1'b0;

    cnt = 0; exp_pc = 32'd0; done = 1'b0; spc = 32'd0;
    for (int it = 0; it < 2000 && !done; it++) begin
      cnt++;
      if (cnt == 1) begin
        spc = pc;
        check("R7", "instruction start pc", spc, exp_pc);
      end
      if (ret) begin
        check((spc == 32'd84 || spc == 32'd88) ? "R10" : "R9", "clocks per instruction",
              32'(cnt), 32'(ref_len(prog[spc[6:2]])));
        src = (prog[spc[6:2]][25:21] == 5'd2) ? b : 32'd0;
        if (prog[spc[6:2]][31:26] == 6'h04 && src == 32'd0)
          exp_pc = spc + 32'd4 + {{16{prog[spc[6:2]][15]}}, prog[spc[6:2]][15:0]};
        else
          exp_pc = spc + 32'd4;
        if (spc == HALT_PC) done = 1'b1;
        cnt = 0;
      end
      if (!done) @(negedge clk);
    end
    if (!done) check("R9", "program reached halt", 32'd0, 32'd1);

    er[0]  = 32'd0;
    er[1]  = a;
    er[2]  = b;
    er[3]  = ref_op(0, a, b);
    er[4]  = ref_op(1, a, b);
    er[5]  = ref_op(2, a, b);
    er[6]  = ref_op(3, a, b);
    er[7]  = ref_op(4, a, b);
    er[8]  = ref_op(5, a, b);
    er[9]  = ref_op(0, a, ks);
    er[10] = ref_op(2, a, ks);
    er[11] = ref_op(3, a, ks);
    er[12] = ref_op(4, a, ks);
    er[13] = ref_op(5, a, ks);
    er[14] = ref_op(0, a, b);
    er[15] = (b == 32'd0) ? 32'd3 : 32'd7;
    for (int r = 0; r < 16; r++) begin
      dsel = 5'(r);
      #1;
      if (r == 0)       check("R8", "r0 after write", ddata, er[r]);
      else if (r < 3)   check("R5", $sformatf("load into r%0d", r), ddata, er[r]);
      else if (r < 9)   check("R3", $sformatf("reg-reg into r%0d", r), ddata, er[r]);
      else if (r < 14)  check("R4", $sformatf("reg-imm into r%0d", r), ddata, er[r]);
      else if (r == 14) check("R6", "stored word read back", ddata, er[r]);
      else              check("R7", "branch outcome in r15", ddata, er[r]);
    end
    check("R2", "skipped write left r1", er[1], a);
    dsel = 5'd0;
    @(negedge clk);
  endtask

  initial begin
    run_vec(32'd5,          32'd3,          16'd7);
    run_vec(32'd0,          32'd9,          16'hFFFF);
    run_vec(32'hFFFF_FFF8,  32'd2,          16'h7FFF);
    run_vec(32'h7FFF_FFFF,  32'hFFFF_FFFF,  16'h8000);
    run_vec(32'd12,         32'd0,          16'd100);
    run_vec(32'd1,          32'd1,          16'hFFFB);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule